// File: doc/BRIEF.md
# Flash ECC Register and Interrupt Front End

This block is the register file and interrupt logic that sits in front of a flash error-correction unit made of a separate parity encoder and a separate syndrome decoder. A host reads and writes byte-addressed 32-bit registers. Through them it switches each engine on or off, stores the configuration words the engines consume, and polls whether each engine is idle. The two engine datapaths are outside the block. Each one is seen only through a small set of signals: a go level and a configuration word going out, and busy, done, sector index, error count and a failure flag coming back.

The encoder and the decoder each have their own register bank. The decoder keeps a bitmap of the sectors it has finished and an 8-bit error count per sector, packed four to a word. When the decoder is enabled from the off state, the bitmap and the counts are wiped. Each bank has an interrupt enable and a pending status. The decoder interrupt can be raised after every correction step or only once the last sector of a page is done. One interrupt line carries both banks.

Top module: `ecc_csr_front`

## Requirements
- R1: After reset, every stored register reads zero, `enc_go`, `dec_go` and `irq` are low, and each idle register reads 1 when its engine is not busy.
- R2: A write to a control register (encoder 0x000, decoder 0x100) stores bit 0, which drives `enc_go` or `dec_go`. Writes to the config words (0x004, 0x104) and to the encoder data address (0x008) are stored whole, drive `enc_cfg`, `dec_cfg` and `enc_addr`, and read back unchanged. Read data appears on `rdata` on the cycle after `rd_en`.
- R3: Bit 0 of the idle registers (0x00C, 0x10C) reads the inverse of `enc_busy` or `dec_busy`. The other bits read zero.
- R4: The encoder status bit (0x084, bit 0) is set by an `enc_done` pulse only while bit 0 of the encoder interrupt enable (0x080) is 1.
- R5: In step mode (decoder enable 0x200 bit 1 = 0, bit 0 = 1), every `dec_done` pulse sets the decoder status bit (0x204, bit 0).
- R6: In page mode (0x200 bit 1 = 1), only a `dec_done` whose `dec_sector` equals the last-sector field (0x200 bits 8 and up) sets the decoder status bit.
- R7: A write to an interrupt enable register with bit 0 = 0 clears that bank's status. This clear wins over a done pulse in the same cycle. `irq` is high while either status bit is set.
- R8: A `dec_done` pulse sets bit `dec_sector` of the done bitmap at 0x124.
- R9: The count for sector i sits in the word at 0x114 + 4*(i/4), in bits [8*(i%4)+7 : 8*(i%4)]. It saturates at the mask 2^ERR_W-1. A pulse with `dec_fail` high stores the mask, which marks the sector as uncorrectable.
- R10: A write of 1 to decoder control while `dec_go` is 0 clears the bitmap and all count words. A write of 1 while `dec_go` is already 1 clears nothing.
- R11: Reads from unmapped offsets return zero. Writes to the idle, status, bitmap and count registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | ADDR_W | byte offset of the register |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data, valid the cycle after rd_en |
| enc_go | output | 1 | encoder enable level |
| enc_cfg | output | 32 | encoder configuration word |
| enc_addr | output | 32 | encoder data address |
| enc_busy | input | 1 | encoder working |
| enc_done | input | 1 | encoder finished pulse |
| dec_go | output | 1 | decoder enable level |
| dec_cfg | output | 32 | decoder configuration word |
| dec_busy | input | 1 | decoder working |
| dec_done | input | 1 | decoder sector finished pulse |
| dec_sector | input | SECT_W | index of the finished sector |
| dec_errcnt | input | 8 | bit errors found in the sector |
| dec_fail | input | 1 | sector could not be corrected |
| irq | output | 1 | combined interrupt |

## Verification
The decoder is driven with random sequences of sector completions, with random indices, counts that cross the saturation mask, and occasional failure flags. Reading back every count word and the bitmap then shows whether lane placement, saturation and the uncorrectable marking are each correct. Directed sequences compare step mode with page mode by sending a done for a sector that is not the last and then for the last one. This separates the two interrupt selections and also exposes the clear-on-write priority. Random config words are written and read back to catch decode aliasing between the two banks. Writes to read-only and unmapped offsets show that stored state is left alone.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
   localparam int unsigned REG_W = 32;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned LANES_PER_WORD = REG_W / LANE_W;

   // encoder bank byte offsets
   localparam logic [31:0] OFS_ENC_CTRL = 32'h000;
   localparam logic [31:0] OFS_ENC_CFG  = 32'h004;
   localparam logic [31:0] OFS_ENC_ADDR = 32'h008;
   localparam logic [31:0] OFS_ENC_IDLE = 32'h00C;
   localparam logic [31:0] OFS_ENC_IE   = 32'h080;
   localparam logic [31:0] OFS_ENC_STA  = 32'h084;
   // decoder bank byte offsets
   localparam logic [31:0] OFS_DEC_CTRL = 32'h100;
   localparam logic [31:0] OFS_DEC_CFG  = 32'h104;
   localparam logic [31:0] OFS_DEC_IDLE = 32'h10C;
   localparam logic [31:0] OFS_DEC_ERR0 = 32'h114;
   localparam logic [31:0] OFS_DEC_DONE = 32'h124;
   localparam logic [31:0] OFS_DEC_IE   = 32'h200;
   localparam logic [31:0] OFS_DEC_STA  = 32'h204;

   // interrupt enable bit positions
   localparam int unsigned IE_EN_BIT   = 0;
   localparam int unsigned IE_PAGE_BIT = 1;
   localparam int unsigned IE_LAST_LSB = 8;

   // largest count word block that fits below the bitmap register
   localparam int unsigned MAX_ERR_WORDS = (OFS_DEC_DONE - OFS_DEC_ERR0) / 4;
endpackage

// File: rtl/ecc_irq_cell.sv
module ecc_irq_cell #(
   parameter int unsigned SECT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_wr,
   input  logic              en,
   input  logic              page_sel,
   input  logic [SECT_W-1:0] last_sec,
   input  logic              done,
   input  logic [SECT_W-1:0] sector,
   output logic              sta
);
   logic hit;

   // In page mode only the last sector of the page counts.
   always_comb begin
      hit = done & en;
      if (page_sel && (sector != last_sec)) hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sta <= 1'b0;
      else if (clr_wr) sta <= 1'b0;
      else if (hit)    sta <= 1'b1;
   end
endmodule

// File: rtl/ecc_sector_log.sv
module ecc_sector_log
   import ecc_csr_pkg::*;
#(
   parameter int unsigned SECTORS = 8,
   parameter int unsigned ERR_W   = 6,
   localparam int unsigned SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1,
   localparam int unsigned WORDS  = SECTORS / LANES_PER_WORD
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  done,
   input  logic [SECT_W-1:0]     sector,
   input  logic [LANE_W-1:0]     errcnt,
   input  logic                  fail,
   output logic [SECTORS-1:0]    done_map,
   output logic [WORDS*REG_W-1:0] err_words
);
   localparam logic [ERR_W-1:0] MASK = {ERR_W{1'b1}};

   logic [ERR_W-1:0] cnt_in;

   // saturate; a failed sector is reported as the full mask
   always_comb begin
      if (fail || (errcnt >= LANE_W'(MASK))) cnt_in = MASK;
      else                                   cnt_in = errcnt[ERR_W-1:0];
   end

   for (genvar s = 0; s < SECTORS; s++) begin : g_sec
      logic [ERR_W-1:0] lane_q;
      logic             hit;

      assign hit = done && (sector == SECT_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q      <= '0;
            done_map[s] <= 1'b0;
         end else if (clr) begin
            lane_q      <= '0;
            done_map[s] <= 1'b0;
         end else if (hit) begin
            lane_q      <= cnt_in;
            done_map[s] <= 1'b1;
         end
      end

      assign err_words[s*LANE_W +: LANE_W] = LANE_W'(lane_q);
   end
endmodule

// File: rtl/ecc_csr_front.sv
module ecc_csr_front
   import ecc_csr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned SECTORS = 8,
   parameter int unsigned ERR_W   = 6,
   localparam int unsigned SECT_W = (SECTORS > 1) ? $clog2(SECTORS) : 1,
   localparam int unsigned WORDS  = SECTORS / LANES_PER_WORD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              enc_go,
   output logic [31:0]       enc_cfg,
   output logic [31:0]       enc_addr,
   input  logic              enc_busy,
   input  logic              enc_done,
   output logic              dec_go,
   output logic [31:0]       dec_cfg,
   input  logic              dec_busy,
   input  logic              dec_done,
   input  logic [SECT_W-1:0] dec_sector,
   input  logic [7:0]        dec_errcnt,
   input  logic              dec_fail,
   output logic              irq
);
   // elaboration checks
   if (ADDR_W < 10 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must be 10..32");
   end
   if (SECTORS < 4 || (SECTORS % LANES_PER_WORD) != 0) begin : g_bad_sect
      $error("SECTORS must be a nonzero multiple of four");
   end
   if (WORDS > MAX_ERR_WORDS) begin : g_bad_words
      $error("SECTORS exceeds the count word space");
   end
   if (ERR_W < 1 || ERR_W > LANE_W) begin : g_bad_errw
      $error("ERR_W must be 1..8");
   end

   logic [31:0] a32;
   assign a32 = 32'(addr);

   logic [1:0]        enc_ie;
   logic [1:0]        dec_ie;
   logic [SECT_W-1:0] dec_last;
   logic              enc_sta, dec_sta;
   logic              dec_clr;
   logic [SECTORS-1:0]     done_map;
   logic [WORDS*REG_W-1:0] err_words;

   logic wr_enc_ie, wr_dec_ie;
   assign wr_enc_ie = wr_en && (a32 == OFS_ENC_IE);
   assign wr_dec_ie = wr_en && (a32 == OFS_DEC_IE);
   // decoder start: write of 1 while the decoder is off
   assign dec_clr = wr_en && (a32 == OFS_DEC_CTRL) && wdata[0] && !dec_go;

   // writable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_go   <= 1'b0;
         enc_cfg  <= '0;
         enc_addr <= '0;
         enc_ie   <= '0;
         dec_go   <= 1'b0;
         dec_cfg  <= '0;
         dec_ie   <= '0;
         dec_last <= '0;
      end else if (wr_en) begin
         unique case (a32)
            OFS_ENC_CTRL: enc_go   <= wdata[0];
            OFS_ENC_CFG:  enc_cfg  <= wdata;
            OFS_ENC_ADDR: enc_addr <= wdata;
            OFS_ENC_IE:   enc_ie   <= wdata[1:0];
            OFS_DEC_CTRL: dec_go   <= wdata[0];
            OFS_DEC_CFG:  dec_cfg  <= wdata;
            OFS_DEC_IE: begin
               dec_ie   <= wdata[1:0];
               dec_last <= wdata[IE_LAST_LSB +: SECT_W];
            end
            default: ;
         endcase
      end
   end

   ecc_irq_cell #(.SECT_W(SECT_W)) u_enc_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_wr   (wr_enc_ie && !wdata[IE_EN_BIT]),
      .en       (enc_ie[IE_EN_BIT]),
      .page_sel (1'b0),
      .last_sec ('0),
      .done     (enc_done),
      .sector   ('0),
      .sta      (enc_sta)
   );

   ecc_irq_cell #(.SECT_W(SECT_W)) u_dec_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_wr   (wr_dec_ie && !wdata[IE_EN_BIT]),
      .en       (dec_ie[IE_EN_BIT]),
      .page_sel (dec_ie[IE_PAGE_BIT]),
      .last_sec (dec_last),
      .done     (dec_done),
      .sector   (dec_sector),
      .sta      (dec_sta)
   );

   assign irq = enc_sta | dec_sta;

   ecc_sector_log #(.SECTORS(SECTORS), .ERR_W(ERR_W)) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (dec_clr),
      .done      (dec_done),
      .sector    (dec_sector),
      .errcnt    (dec_errcnt),
      .fail      (dec_fail),
      .done_map  (done_map),
      .err_words (err_words)
   );

   // read decode
   logic [31:0] rd_val;
   always_comb begin
      rd_val = '0;
      unique case (a32)
         OFS_ENC_CTRL: rd_val = {31'd0, enc_go};
         OFS_ENC_CFG:  rd_val = enc_cfg;
         OFS_ENC_ADDR: rd_val = enc_addr;
         OFS_ENC_IDLE: rd_val = {31'd0, !enc_busy};
         OFS_ENC_IE:   rd_val = {30'd0, enc_ie};
         OFS_ENC_STA:  rd_val = {31'd0, enc_sta};
         OFS_DEC_CTRL: rd_val = {31'd0, dec_go};
         OFS_DEC_CFG:  rd_val = dec_cfg;
         OFS_DEC_IDLE: rd_val = {31'd0, !dec_busy};
         OFS_DEC_DONE: rd_val = 32'(done_map);
         OFS_DEC_IE: begin
            rd_val = {30'd0, dec_ie};
            rd_val[IE_LAST_LSB +: SECT_W] = dec_last;
         end
         OFS_DEC_STA:  rd_val = {31'd0, dec_sta};
         default: begin
            for (int w = 0; w < WORDS; w++) begin
               if (a32 == OFS_DEC_ERR0 + 32'(4 * w)) rd_val = err_words[w*REG_W +: REG_W];
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end
endmodule

// File: rtl/ecc_csr_front_chk.sv
module ecc_csr_front_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned SECTORS = 8,
   parameter int unsigned SECT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic              enc_go,
   input logic              dec_go,
   input logic              enc_done,
   input logic [1:0]        enc_ie,
   input logic              enc_sta,
   input logic              dec_sta,
   input logic              dec_done,
   input logic [SECT_W-1:0] dec_sector,
   input logic [SECTORS-1:0] done_map,
   input logic              irq
);
   logic [31:0] a32;
   assign a32 = 32'(addr);

   // R2: control write lands on the go level
   p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == 32'h000) |=> (enc_go == $past(wdata[0])));

   // R4: encoder status needs its enable
   p_enc_sta_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!enc_sta && !enc_ie[0]) |=> !enc_sta);

   p_enc_sta_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_done && enc_ie[0] && !(wr_en && a32 == 32'h080)) |=> enc_sta);

   // R7: clear by write of enable bit 0
   p_dec_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == 32'h200 && !wdata[0]) |=> !dec_sta);

   p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!enc_sta && !dec_sta) |-> !irq);

   // R8: done pulse marks its sector unless a start clears the map
   p_done_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_done && 32'(dec_sector) < SECTORS &&
       !(wr_en && a32 == 32'h100 && wdata[0] && !dec_go))
      |=> done_map[$past(dec_sector)]);

   // R10: start from off wipes the bitmap
   p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && a32 == 32'h100 && wdata[0] && !dec_go) |=> (done_map == '0));

   // R11: unmapped read returns zero
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && a32 == 32'h040) |=> (rdata == 32'd0));
endmodule

bind ecc_csr_front ecc_csr_front_chk #(
   .ADDR_W (ADDR_W),
   .SECTORS(SECTORS),
   .SECT_W (SECT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .addr       (addr),
   .wdata      (wdata),
   .rdata      (rdata),
   .enc_go     (enc_go),
   .dec_go     (dec_go),
   .enc_done   (enc_done),
   .enc_ie     (enc_ie),
   .enc_sta    (enc_sta),
   .dec_sta    (dec_sta),
   .dec_done   (dec_done),
   .dec_sector (dec_sector),
   .done_map   (done_map),
   .irq        (irq)
);

// File: tb/ecc_csr_front_bench.sv
module ecc_csr_front_bench;
   localparam int ADDR_W = 12;
   localparam int SECTORS = 8;
   localparam int ERR_W = 6;
   localparam int SECT_W = 3;
   localparam int MASK = (1 << ERR_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic enc_go, dec_go, irq;
   logic [31:0] enc_cfg, enc_addr, dec_cfg;
   logic enc_busy = 0, enc_done = 0, dec_busy = 0, dec_done = 0, dec_fail = 0;
   logic [SECT_W-1:0] dec_sector = '0;
   logic [7:0] dec_errcnt = '0;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_lane [SECTORS];
   logic [SECTORS-1:0] m_done;

   always #2 clk = ~clk;

   ecc_csr_front #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .ERR_W(ERR_W)) u_ecc_csr_front (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .enc_go(enc_go), .enc_cfg(enc_cfg),
      .enc_addr(enc_addr), .enc_busy(enc_busy), .enc_done(enc_done),
      .dec_go(dec_go), .dec_cfg(dec_cfg), .dec_busy(dec_busy),
      .dec_done(dec_done), .dec_sector(dec_sector), .dec_errcnt(dec_errcnt),
      .dec_fail(dec_fail), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a[ADDR_W-1:0]; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1; addr = a[ADDR_W-1:0];
      @(negedge clk);
      rd_en = 0; d = rdata;
   endtask

   task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   function automatic logic [7:0] sat(input logic [7:0] c, input logic f);
      if (f || c >= 8'(MASK)) return 8'(MASK);
      return c;
   endfunction

   function automatic logic [31:0] exp_word(input int w);
      return {m_lane[4*w+3], m_lane[4*w+2], m_lane[4*w+1], m_lane[4*w]};
   endfunction

   task automatic dec_pulse(input int s, input logic [7:0] c, input logic f);
      @(negedge clk);
      dec_done = 1; dec_sector = SECT_W'(s); dec_errcnt = c; dec_fail = f;
      @(negedge clk);
      dec_done = 0; dec_fail = 0;
      m_done[s] = 1'b1;
      m_lane[s] = sat(c, f);
   endtask

   task automatic enc_pulse();
      @(negedge clk);
      enc_done = 1;
      @(negedge clk);
      enc_done = 0;
   endtask

   task automatic model_clear();
      m_done = '0;
      for (int i = 0; i < SECTORS; i++) m_lane[i] = '0;
   endtask

   task automatic check_log(input string req);
      rd_chk(req, 32'h124, 32'(m_done));
      for (int w = 0; w < SECTORS / 4; w++) rd_chk(req, 32'h114 + 32'(4 * w), exp_word(w));
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5eed_0426));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state, R3 idle
      chk("R1 enc_go", 32'(enc_go), 0);
      chk("R1 dec_go", 32'(dec_go), 0);
      chk("R1 irq", 32'(irq), 0);
      rd_chk("R1 enc_cfg", 32'h004, 0);
      rd_chk("R1 dec_cfg", 32'h104, 0);
      rd_chk("R1 dec_ie", 32'h200, 0);
      rd_chk("R1 done", 32'h124, 0);
      rd_chk("R1 R3 enc idle", 32'h00C, 1);
      rd_chk("R1 R3 dec idle", 32'h10C, 1);

      // R3 busy reflection
      enc_busy = 1; dec_busy = 1;
      rd_chk("R3 enc busy", 32'h00C, 0);
      rd_chk("R3 dec busy", 32'h10C, 0);
      enc_busy = 0; dec_busy = 0;

      // R2 control and config
      wr(32'h000, 32'hFFFF_FFFF);
      chk("R2 enc_go", 32'(enc_go), 1);
      rd_chk("R2 enc ctrl", 32'h000, 1);
      wr(32'h000, 32'h0000_0002);
      chk("R2 enc_go off", 32'(enc_go), 0);
      for (int i = 0; i < 10; i++) begin
         logic [31:0] a, b, c;
         a = $urandom; b = $urandom; c = $urandom;
         wr(32'h004, a); wr(32'h008, b); wr(32'h104, c);
         chk("R2 enc_cfg port", enc_cfg, a);
         chk("R2 enc_addr port", enc_addr, b);
         chk("R2 dec_cfg port", dec_cfg, c);
         rd_chk("R2 enc_cfg rd", 32'h004, a);
         rd_chk("R2 enc_addr rd", 32'h008, b);
         rd_chk("R2 dec_cfg rd", 32'h104, c);
      end

      // R4 encoder interrupt
      enc_pulse();
      rd_chk("R4 disabled", 32'h084, 0);
      chk("R4 irq off", 32'(irq), 0);
      wr(32'h080, 1);
      enc_pulse();
      rd_chk("R4 enabled", 32'h084, 1);
      chk("R7 irq enc", 32'(irq), 1);
      wr(32'h080, 0);
      rd_chk("R7 enc clear", 32'h084, 0);
      chk("R7 irq clear", 32'(irq), 0);

      // R10 start decoder, R8 R9 logging with random stimulus
      wr(32'h100, 1);
      chk("R2 dec_go", 32'(dec_go), 1);
      for (int i = 0; i < 40; i++) begin
         int s;
         logic [7:0] c;
         logic f;
         s = int'($urandom_range(SECTORS - 1, 0));
         c = 8'($urandom_range(80, 0));
         f = ($urandom_range(7, 0) == 0);
         dec_pulse(s, c, f);
         if (i % 10 == 9) check_log("R8 R9 random");
      end
      // directed saturation corners
      dec_pulse(0, 8'(MASK - 1), 0);
      dec_pulse(5, 8'(MASK), 0);
      dec_pulse(6, 8'hFF, 0);
      dec_pulse(7, 8'd0, 1);
      check_log("R9 saturate");

      // R11 read-only writes ignored, unmapped reads zero
      wr(32'h124, 32'hFFFF_FFFF);
      wr(32'h114, 32'h0);
      wr(32'h118, 32'h0);
      wr(32'h084, 32'h1);
      wr(32'h10C, 32'h0);
      check_log("R11 ro write");
      rd_chk("R11 sta ro", 32'h084, 0);
      rd_chk("R11 idle ro", 32'h10C, 1);
      rd_chk("R11 unmapped 040", 32'h040, 0);
      rd_chk("R11 unmapped 300", 32'h300, 0);
      rd_chk("R11 unmapped 11C", 32'h11C, 0);

      // R10 rewrite of 1 while running keeps log
      wr(32'h100, 1);
      check_log("R10 no clear");
      wr(32'h100, 0);
      wr(32'h100, 1);
      model_clear();
      check_log("R10 clear");

      // R5 step mode
      wr(32'h200, 1);
      dec_pulse(2, 8'd3, 0);
      rd_chk("R5 step", 32'h204, 1);
      chk("R7 irq dec", 32'(irq), 1);
      wr(32'h200, 0);
      rd_chk("R7 dec clear", 32'h204, 0);

      // R6 page mode, last sector 7 in bits 10:8
      wr(32'h200, 32'h0000_0703);
      rd_chk("R6 ie readback", 32'h200, 32'h0000_0703);
      dec_pulse(3, 8'd1, 0);
      rd_chk("R6 not last", 32'h204, 0);
      chk("R6 irq off", 32'(irq), 0);
      dec_pulse(7, 8'd2, 0);
      rd_chk("R6 last", 32'h204, 1);

      // R7 clear wins over simultaneous done
      @(negedge clk);
      wr_en = 1; addr = 12'h200; wdata = 32'h0;
      dec_done = 1; dec_sector = 3'd7; dec_errcnt = 8'd1;
      @(negedge clk);
      wr_en = 0; dec_done = 0;
      m_done[7] = 1'b1; m_lane[7] = 8'd1;
      rd_chk("R7 clear priority", 32'h204, 0);
      check_log("R8 with clear");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule